// File: doc/BRIEF.md
# 32-Pin GPIO Register Bank with Edge-Triggered Interrupts

This block is a register bank that controls 32 general-purpose pins. A small memory-mapped port carries an address, a write strobe, write data and combinational read data. Software uses it to pick each pin's direction and to drive output levels. It also reads back the pin levels and arms edge detection for each pin. Output levels and trigger enables have no direct write. They change only through paired set and clear registers, where a 1 bit acts and a 0 bit leaves the pin alone. This lets several agents change different pins without a read-modify-write race.

Each pin level passes through a two-flop synchronizer before it is read or used. An edge is found by comparing the synchronized level with its value one clock earlier. When an edge matches an armed trigger, a sticky event flag is set. The 32 flags split into two 16-pin groups. Each group drives its own interrupt line, and each line is gated by its own enable bit.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every pin is an input (direction bits 1), the output levels are 0, all rising and falling trigger enables are 0, all event flags are 0, both group enables are 0, and both interrupt lines are low.
- R2: Writing to offset 0x08 sets each output bit whose write-data bit is 1 and leaves the others unchanged. Reads of 0x04, 0x08 and 0x0C all return the output levels, which also appear on `gpio_out`.
- R3: Writing to offset 0x0C clears each output bit whose write-data bit is 1 and leaves the others unchanged.
- R4: Offset 0x00 is the read/write direction register (1 = input). `gpio_oe` is its bitwise inverse. Writes to offset 0x04 have no effect.
- R5: Offset 0x10 returns the pin level two clock edges after `pin_in` changes, whatever the pin's direction.
- R6: Writing to 0x14 sets rising-edge enables and writing to 0x18 clears them, both with a 1 bit acting. Reads of either offset return the rising enables.
- R7: Writing to 0x1C sets falling-edge enables and writing to 0x20 clears them, in the same way. Reads of either offset return the falling enables.
- R8: An edge on a pin whose matching enable is 1 sets that pin's flag at offset 0x24 on the clock edge after the new level first shows at 0x10. An edge on a pin whose matching enable is 0 leaves the flags unchanged.
- R9: Writing 1s to 0x24 clears those flags. If an enabled edge on a pin lands in the same cycle as the clear of that pin's flag, the flag stays set.
- R10: `irq[0]` is high exactly when some flag in bits 15:0 is set and bit 0 of offset 0x28 is 1. `irq[1]` does the same for bits 31:16 and bit 1 of offset 0x28.
- R11: Reads of any offset other than the eleven listed above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pin-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte offset of the register |
| wr_en | input | 1 | Write strobe, acts on the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| gpio_out | output | 32 | Output level for each pin |
| gpio_oe | output | 32 | Output enable for each pin (1 = drive) |
| irq | output | 2 | Interrupt line for each 16-pin group |

## Verification
Two things can happen on the same clock edge: a software write that clears event flags, and a newly detected edge that sets one. The bench first arms falling detection and sets a flag. It then drops that pin and times a clear of the same flag so the strobe is present on the very edge where the synchronized fall is seen. In the same write it clears a second flag that has no edge. It expects the first flag to stay set and the second to clear. Stepwise sweeps across all 32 pins check flag latching, the group gating of each interrupt line, and the output set and clear registers against a model the bench keeps.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int NPINS  = 32;
    localparam int ADDR_W = 6;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFF_DIR       = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_OUT_LVL   = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_OUT_SET   = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_OUT_CLR   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_PIN_LVL   = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_RISE_ON   = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_RISE_OFF  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_FALL_ON   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_FALL_OFF  = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_EVT_FLAGS = 6'h24;
    localparam logic [ADDR_W-1:0] OFF_GRP_EN    = 6'h28;

    typedef logic [NPINS-1:0] pin_vec_t;

    // Trigger enables for both polarities
    typedef struct packed {
        pin_vec_t rise;
        pin_vec_t fall;
    } trig_t;

    // Decoded write strobes
    typedef struct packed {
        logic dir;
        logic out_set;
        logic out_clr;
        logic rise_on;
        logic rise_off;
        logic fall_on;
        logic fall_off;
        logic evt_clr;
        logic grp_en;
    } wr_strobe_t;

    // Apply a one-acts set/clear pair to a vector
    function automatic pin_vec_t apply_pair(pin_vec_t cur, logic do_set,
                                            logic do_clr, pin_vec_t mask);
        pin_vec_t nxt;
        nxt = cur;
        if (do_set) nxt = nxt | mask;
        if (do_clr) nxt = nxt & ~mask;
        return nxt;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign level = lvl_q;
    assign rise  = lvl_q & ~prev_q;
    assign fall  = ~lvl_q & prev_q;
endmodule

// File: rtl/gpio_evt_flags.sv
module gpio_evt_flags #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hit,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_q;

    // A new hit wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_mask) | hit;
    end

    assign flags = flags_q;
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq #(
    parameter int W      = 32,
    parameter int BANK_W = 16,
    localparam int NGRP  = W / BANK_W
) (
    input  logic [W-1:0]    flags,
    input  logic [NGRP-1:0] grp_en,
    output logic [NGRP-1:0] irq
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign irq[g] = grp_en[g] & (|flags[g*BANK_W +: BANK_W]);
    end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
    parameter int BANK_W = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [gpio_edge_pkg::ADDR_W-1:0]       addr,
    input  logic                                   wr_en,
    input  logic [gpio_edge_pkg::NPINS-1:0]        wdata,
    output logic [gpio_edge_pkg::NPINS-1:0]        rdata,
    input  logic [gpio_edge_pkg::NPINS-1:0]        pin_in,
    output logic [gpio_edge_pkg::NPINS-1:0]        gpio_out,
    output logic [gpio_edge_pkg::NPINS-1:0]        gpio_oe,
    output logic [gpio_edge_pkg::NPINS/BANK_W-1:0] irq
);
    import gpio_edge_pkg::*;

    localparam int NGRP = NPINS / BANK_W;

    pin_vec_t        dir_q;
    pin_vec_t        out_q;
    trig_t           trig_q;
    logic [NGRP-1:0] grp_en_q;
    wr_strobe_t      stb;

    pin_vec_t pin_lvl, pin_rise, pin_fall;
    pin_vec_t evt_hit, evt_clr, evt_flags;

    // Write decode
    always_comb begin
        stb          = '0;
        stb.dir      = wr_en && (addr == OFF_DIR);
        stb.out_set  = wr_en && (addr == OFF_OUT_SET);
        stb.out_clr  = wr_en && (addr == OFF_OUT_CLR);
        stb.rise_on  = wr_en && (addr == OFF_RISE_ON);
        stb.rise_off = wr_en && (addr == OFF_RISE_OFF);
        stb.fall_on  = wr_en && (addr == OFF_FALL_ON);
        stb.fall_off = wr_en && (addr == OFF_FALL_OFF);
        stb.evt_clr  = wr_en && (addr == OFF_EVT_FLAGS);
        stb.grp_en   = wr_en && (addr == OFF_GRP_EN);
    end

    // Control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= '1;
            out_q    <= '0;
            trig_q   <= '0;
            grp_en_q <= '0;
        end else begin
            if (stb.dir) dir_q <= wdata;
            out_q       <= apply_pair(out_q, stb.out_set, stb.out_clr, wdata);
            trig_q.rise <= apply_pair(trig_q.rise, stb.rise_on, stb.rise_off, wdata);
            trig_q.fall <= apply_pair(trig_q.fall, stb.fall_on, stb.fall_off, wdata);
            if (stb.grp_en) grp_en_q <= wdata[NGRP-1:0];
        end
    end

    gpio_pin_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (pin_in),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign evt_hit = (pin_rise & trig_q.rise) | (pin_fall & trig_q.fall);
    assign evt_clr = stb.evt_clr ? wdata : '0;

    gpio_evt_flags #(.W(NPINS)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .hit      (evt_hit),
        .clr_mask (evt_clr),
        .flags    (evt_flags)
    );

    gpio_group_irq #(.W(NPINS), .BANK_W(BANK_W)) u_irq (
        .flags  (evt_flags),
        .grp_en (grp_en_q),
        .irq    (irq)
    );

    // Read mux
    always_comb begin
        rdata = '0;
        case (addr)
            OFF_DIR:                            rdata = dir_q;
            OFF_OUT_LVL, OFF_OUT_SET, OFF_OUT_CLR: rdata = out_q;
            OFF_PIN_LVL:                        rdata = pin_lvl;
            OFF_RISE_ON, OFF_RISE_OFF:          rdata = trig_q.rise;
            OFF_FALL_ON, OFF_FALL_OFF:          rdata = trig_q.fall;
            OFF_EVT_FLAGS:                      rdata = evt_flags;
            OFF_GRP_EN:                         rdata[NGRP-1:0] = grp_en_q;
            default:                            rdata = '0;
        endcase
    end

    assign gpio_out = out_q;
    assign gpio_oe  = ~dir_q;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
    parameter int W      = 32,
    parameter int BANK_W = 16,
    localparam int NGRP  = W / BANK_W
) (
    input logic            clk,
    input logic            rst,
    input logic [5:0]      addr,
    input logic            wr_en,
    input logic [W-1:0]    wdata,
    input logic [W-1:0]    out_q,
    input logic [W-1:0]    rise_en,
    input logic [W-1:0]    fall_en,
    input logic [W-1:0]    flags,
    input logic [W-1:0]    hit,
    input logic [NGRP-1:0] grp_en,
    input logic [NGRP-1:0] irq
);
    import gpio_edge_pkg::*;

    p_trig_off_r1: assert property (@(posedge clk)
        rst |=> (rise_en == '0 && fall_en == '0 && flags == '0));

    p_w1s_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_OUT_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

    p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_OUT_CLR) |=> ((out_q & $past(wdata)) == '0));

    p_edge_latch_r8: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((flags & $past(hit)) == $past(hit)));

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == OFF_EVT_FLAGS) |=> ((flags & $past(flags)) == $past(flags)));

    for (genvar g = 0; g < NGRP; g++) begin : g_chk
        p_grp_gate_r10: assert property (@(posedge clk) disable iff (rst)
            !grp_en[g] |-> !irq[g]);
        p_grp_src_r10: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> (flags[g*BANK_W +: BANK_W] != '0));
    end
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.W(gpio_edge_pkg::NPINS), .BANK_W(BANK_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .out_q   (out_q),
    .rise_en (trig_q.rise),
    .fall_en (trig_q.fall),
    .flags   (evt_flags),
    .hit     (evt_hit),
    .grp_en  (grp_en_q),
    .irq     (irq)
);

// File: tb/test_gpio_edge_bank.sv
module test_gpio_edge_bank;
    logic        clk = 0;
    logic        rst = 1;
    logic [5:0]  addr = '0;
    logic        wr_en = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] gpio_out, gpio_oe;
    logic [1:0]  irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    gpio_edge_bank i_gpio_edge_bank (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .gpio_out(gpio_out),
        .gpio_oe(gpio_oe), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, model, lf, s, c, flags_exp;
        step(3);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(6'h00, v); check("R1 dir", v, 32'hFFFF_FFFF);
        rd(6'h04, v); check("R1 out", v, 32'h0);
        rd(6'h14, v); check("R1 rise", v, 32'h0);
        rd(6'h1C, v); check("R1 fall", v, 32'h0);
        rd(6'h24, v); check("R1 flags", v, 32'h0);
        rd(6'h28, v); check("R1 grp", v, 32'h0);
        check("R1 irq", {30'h0, irq}, 32'h0);

        // R2 / R3 set-clear sweep against a bench model
        model = '0; lf = 32'h1ACE_B00C;
        for (int i = 0; i < 24; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            s  = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            c  = lf & 32'h5F0F_F0F5;
            wr(6'h08, s); model = model | s;
            rd(6'h08, v); check("R2 set", v, model);
            check("R2 port", gpio_out, model);
            wr(6'h0C, c); model = model & ~c;
            rd(6'h0C, v); check("R3 clr", v, model);
            rd(6'h04, v); check("R3 out", v, model);
        end

        // R4 direction and ignored write to 0x04
        wr(6'h00, 32'hA5A5_0F0F);
        rd(6'h00, v); check("R4 dir", v, 32'hA5A5_0F0F);
        check("R4 oe", gpio_oe, 32'h5A5A_F0F0);
        wr(6'h04, ~model);
        rd(6'h04, v); check("R4 out ignore", v, model);
        check("R4 port ignore", gpio_out, model);

        // R5 two-edge input latency, direction irrelevant
        wr(6'h00, 32'h0);
        @(negedge clk); pin_in = 32'h3C3C_C3C3;
        step(1); rd(6'h10, v); check("R5 old", v, 32'h0);
        step(1); rd(6'h10, v); check("R5 new", v, 32'h3C3C_C3C3);
        @(negedge clk); pin_in = 32'h0;
        step(3);
        rd(6'h24, v); check("R8 disabled", v, 32'h0);

        // R6 rising enables
        wr(6'h14, 32'hFFFF_00FF);
        wr(6'h14, 32'h0000_FF00);
        wr(6'h18, 32'h0000_0F00);
        rd(6'h18, v); check("R6 rise", v, 32'hFFFF_F0FF);
        wr(6'h14, 32'h0000_0F00);
        rd(6'h14, v); check("R6 rise all", v, 32'hFFFF_FFFF);

        // R8 per-pin rising sweep, R10 gating
        flags_exp = '0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); pin_in[i] = 1'b1;
            step(1); rd(6'h24, v); check("R8 early", v, flags_exp);
            step(1); rd(6'h10, v); check("R5 sweep", v[i], 1'b1);
            rd(6'h24, v); check("R8 not yet", v, flags_exp);
            flags_exp[i] = 1'b1;
            step(1); rd(6'h24, v); check("R8 latch", v, flags_exp);
            check("R10 off", {30'h0, irq}, 32'h0);
        end
        wr(6'h28, 32'h1); check("R10 g0", {30'h0, irq}, 32'h1);
        wr(6'h28, 32'h2); check("R10 g1", {30'h0, irq}, 32'h2);
        wr(6'h28, 32'h3);
        wr(6'h24, 32'h0000_FFFF);
        rd(6'h24, v); check("R9 clear", v, 32'hFFFF_0000);
        check("R10 half", {30'h0, irq}, 32'h2);
        wr(6'h24, 32'hFFFF_0000);
        check("R10 none", {30'h0, irq}, 32'h0);

        // R7 falling enables; rise disabled so raising does nothing
        wr(6'h18, 32'hFFFF_FFFF);
        rd(6'h14, v); check("R6 rise off", v, 32'h0);
        wr(6'h1C, 32'h00F0_00F3);
        wr(6'h20, 32'h0000_0003);
        rd(6'h20, v); check("R7 fall", v, 32'h00F0_00F0);
        @(negedge clk); pin_in = 32'h0;
        step(3);
        rd(6'h24, v); check("R7 fall latch", v, 32'h00F0_00F0);
        check("R10 both", {30'h0, irq}, 32'h3);
        @(negedge clk); pin_in = 32'hFFFF_FFFF;
        step(3);
        rd(6'h24, v); check("R8 rise ignored", v, 32'h00F0_00F0);

        // R9 collision: clear bit 4 on the edge its fall is detected, and bit 20 without edge
        @(negedge clk); pin_in[4] = 1'b0;
        step(1);
        @(negedge clk); addr = 6'h24; wdata = 32'h0010_0010; wr_en = 1;
        @(negedge clk); wr_en = 0;
        rd(6'h24, v); check("R9 collide", v, 32'h00E0_0010 | 32'h0000_00E0);
        wr(6'h24, 32'hFFFF_FFFF);
        rd(6'h24, v); check("R9 all clear", v, 32'h0);

        // R11 unmapped offsets
        for (int a = 16'h2C; a < 64; a += 4) begin
            rd(a[5:0], v); check("R11 unmapped", v, 32'h0);
        end
        rd(6'h02, v); check("R11 odd", v, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule